// File: doc/BRIEF.md
# Alternator Field-Drive PWM with Load-Response Ramp

This block produces the pulse-width-modulated drive bit for the field winding of an alternator voltage regulator. A fixed-length PWM frame of `2**DUTY_W` timebase ticks is generated. The field bit is high for the first `duty` ticks of each frame. The duty word changes only at a frame boundary. At that boundary the regulation comparator bit ("sensed voltage below setpoint") is captured once and decides the duty for the next frame.

When the phase frequency is below its threshold, load-response control applies. In that mode a demand for more field raises the duty only in fixed increments, and only once every `RATIO` frames. A full 0-to-100% climb therefore takes about `RAMP_PERIODS` frames. Outside that mode a demand for more field drives the duty straight to full scale. A demand for less field always takes effect at the next boundary, with no rate limit. The duty never falls below a minimum set by the voltage window. That minimum is one sixteenth of full scale (6.25%) when the sensed voltage lies between the undervoltage and overvoltage limits, and zero otherwise.

Top module: `field_pwm_ramp`

## Requirements
- R1: A synchronous active-high reset clears the duty word to 0 and holds `field_drive` low.
- R2: The frame counter advances only on cycles with `tick` high, and each frame is `2**DUTY_W` ticks long. In the frame that follows a boundary, `field_drive` is high for exactly `duty` ticks. While `tick` is low, both `duty` and `field_drive` hold their values.
- R3: `below_sp` is sampled only on the last tick of a frame. Its value at any other time has no effect on the duty.
- R4: If `below_sp` is low at a frame boundary, the duty becomes the window minimum at that boundary, whatever its earlier value.
- R5: With `ov_flag` and `uv_flag` both low, the window minimum is `2**DUTY_W/16`, which is 16 for 8-bit duty (6.25%). No boundary leaves the duty below it.
- R6: With `ov_flag` or `uv_flag` high, the window minimum is 0.
- R7: With `slow_phase` high and `below_sp` high at a boundary, the duty rises by `INC` only on every `RATIO`-th frame boundary counted from reset, and saturates at full scale. On the other boundaries it holds, raised to the window minimum if needed.
- R8: With `slow_phase` low and `below_sp` high at a boundary, the duty becomes full scale (255 for 8-bit duty).
- R9: `INC` is the ceiling of full scale divided by `RAMP_PERIODS/RATIO`. For `DUTY_W=8`, `RATIO=4` and `RAMP_PERIODS=40`, `INC` is 26.
- R10: When a ramp-step boundary coincides with `below_sp` low, the drop to the minimum wins and no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable; one PWM tick per high cycle |
| below_sp | input | 1 | Regulation comparator: sensed voltage below setpoint |
| ov_flag | input | 1 | Sensed voltage above overvoltage limit |
| uv_flag | input | 1 | Sensed voltage below undervoltage limit |
| slow_phase | input | 1 | Phase frequency below threshold; enables load-response ramp |
| field_drive | output | 1 | Field-winding PWM drive bit |
| duty | output | DUTY_W | Duty word in force for the current frame |

## Verification
Two events can meet on one frame boundary: the every-`RATIO`-th ramp step and a comparator reading that calls for less field. The bench first ramps the duty part way. It then walks frames until the next boundary is a step slot, drops `below_sp` just before that boundary, and expects the window minimum, not the minimum plus one increment. A second coincidence comes from the window flags. A floor change and the comparator decision take effect together on one boundary, and the checks after an overvoltage or undervoltage frame judge the floor that results.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    // What the duty controller does at a frame boundary.
    typedef enum logic [1:0] {
        ACT_DROP = 2'd0,   // comparator says enough field: fall to floor
        ACT_FULL = 2'd1,   // ramp disabled: jump to full scale
        ACT_STEP = 2'd2,   // ramp enabled and step slot: add increment
        ACT_HOLD = 2'd3    // ramp enabled, no step slot: keep value
    } duty_act_e;

    // Sense inputs captured together at the frame boundary.
    typedef struct packed {
        logic below;
        logic ov;
        logic uv;
        logic slow;
    } sense_t;

    function automatic int ceil_div(input int num, input int den);
        int d;
        d = (den < 1) ? 1 : den;
        return (num + d - 1) / d;
    endfunction

    // Number of ramp steps in a full climb, at least one.
    function automatic int ramp_steps(input int periods, input int ratio);
        int r;
        r = (ratio < 1) ? 1 : ratio;
        return (periods / r < 1) ? 1 : periods / r;
    endfunction

    // Increment per step that reaches full scale within the ramp.
    function automatic int ramp_inc(input int duty_w, input int periods, input int ratio);
        return ceil_div((1 << duty_w) - 1, ramp_steps(periods, ratio));
    endfunction

    // Window floor: one sixteenth of the frame (6.25%).
    function automatic int window_min(input int duty_w);
        return (1 << duty_w) / 16;
    endfunction

endpackage

// File: rtl/fpr_timebase.sv
module fpr_timebase #(
    parameter int DUTY_W = 8,
    parameter int RATIO  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [DUTY_W-1:0] frame_pos,
    output logic              wrap,
    output logic              step_slot
);
    localparam int SW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [SW-1:0] SLOT_LAST = SW'(RATIO - 1);

    logic [DUTY_W-1:0] pos_q;
    logic [SW-1:0]     slot_q;

    assign wrap      = tick && (pos_q == '1);
    assign step_slot = wrap && (slot_q == SLOT_LAST);
    assign frame_pos = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (tick) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    generate
        if (RATIO > 1) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q <= '0;
                end else if (wrap) begin
                    slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
                end
            end
        end else begin : g_noslot
            always_ff @(posedge clk) begin
                slot_q <= '0;
            end
        end
    endgenerate

endmodule

// File: rtl/fpr_duty_ctrl.sv
module fpr_duty_ctrl
    import fpr_pkg::*;
#(
    parameter int DUTY_W       = 8,
    parameter int RATIO        = 4,
    parameter int RAMP_PERIODS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic              step_slot,
    input  sense_t            sense,
    output logic [DUTY_W-1:0] duty
);
    localparam int INC  = ramp_inc(DUTY_W, RAMP_PERIODS, RATIO);
    localparam int MINW = window_min(DUTY_W);
    localparam logic [DUTY_W:0]   INC_V = INC[DUTY_W:0];
    localparam logic [DUTY_W-1:0] MIN_V = MINW[DUTY_W-1:0];

    logic [DUTY_W-1:0] duty_q, duty_d, floor_v, cand, ramp_v;
    logic [DUTY_W:0]   sum;
    duty_act_e         act;

    always_comb begin
        floor_v = (!sense.ov && !sense.uv) ? MIN_V : '0;
        sum     = {1'b0, duty_q} + INC_V;
        ramp_v  = sum[DUTY_W] ? '1 : sum[DUTY_W-1:0];

        if (!sense.below)      act = ACT_DROP;
        else if (!sense.slow)  act = ACT_FULL;
        else if (step_slot)    act = ACT_STEP;
        else                   act = ACT_HOLD;

        unique case (act)
            ACT_DROP: cand = floor_v;
            ACT_FULL: cand = '1;
            ACT_STEP: cand = ramp_v;
            default:  cand = duty_q;
        endcase

        duty_d = (cand < floor_v) ? floor_v : cand;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
        end else if (wrap) begin
            duty_q <= duty_d;
        end
    end

    assign duty = duty_q;

endmodule

// File: rtl/fpr_pwm_out.sv
module fpr_pwm_out #(
    parameter int DUTY_W = 8
) (
    input  logic [DUTY_W-1:0] frame_pos,
    input  logic [DUTY_W-1:0] duty,
    output logic              drive
);
    assign drive = (frame_pos < duty);
endmodule

// File: rtl/field_pwm_ramp.sv
module field_pwm_ramp
    import fpr_pkg::*;
#(
    parameter int DUTY_W       = 8,
    parameter int RATIO        = 4,
    parameter int RAMP_PERIODS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              below_sp,
    input  logic              ov_flag,
    input  logic              uv_flag,
    input  logic              slow_phase,
    output logic              field_drive,
    output logic [DUTY_W-1:0] duty
);
    logic [DUTY_W-1:0] frame_pos;
    logic              wrap;
    logic              step_slot;
    sense_t            sense;

    assign sense = '{below: below_sp, ov: ov_flag, uv: uv_flag, slow: slow_phase};

    fpr_timebase #(.DUTY_W(DUTY_W), .RATIO(RATIO)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .frame_pos (frame_pos),
        .wrap      (wrap),
        .step_slot (step_slot)
    );

    fpr_duty_ctrl #(.DUTY_W(DUTY_W), .RATIO(RATIO), .RAMP_PERIODS(RAMP_PERIODS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wrap      (wrap),
        .step_slot (step_slot),
        .sense     (sense),
        .duty      (duty)
    );

    fpr_pwm_out #(.DUTY_W(DUTY_W)) u_out (
        .frame_pos (frame_pos),
        .duty      (duty),
        .drive     (field_drive)
    );

endmodule

// File: rtl/fpr_checker.sv
module fpr_checker
    import fpr_pkg::*;
#(
    parameter int DUTY_W       = 8,
    parameter int RATIO        = 4,
    parameter int RAMP_PERIODS = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              below_sp,
    input logic              ov_flag,
    input logic              uv_flag,
    input logic              slow_phase,
    input logic              wrap,
    input logic              step_slot,
    input logic              field_drive,
    input logic [DUTY_W-1:0] duty
);
    localparam int INC  = ramp_inc(DUTY_W, RAMP_PERIODS, RATIO);
    localparam int MINW = window_min(DUTY_W);
    localparam int MAXV = (1 << DUTY_W) - 1;

    function automatic int ramp_cap(input int prev);
        int s;
        s = (prev + INC > MAXV) ? MAXV : prev + INC;
        return (s < MINW) ? MINW : s;
    endfunction

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (duty == '0 && !field_drive));

    p_tick_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(duty) && $stable(field_drive)));

    p_boundary_only_r3: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(duty));

    p_drop_window_r4: assert property (@(posedge clk) disable iff (rst)
        (wrap && !below_sp && !ov_flag && !uv_flag) |=> (int'(duty) == MINW));

    p_floor_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (wrap && !below_sp && (ov_flag || uv_flag)) |=> (duty == '0));

    p_ramp_limit_r7: assert property (@(posedge clk) disable iff (rst)
        (wrap && below_sp && slow_phase) |=> (int'(duty) <= ramp_cap(int'($past(duty)))));

    p_ramp_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (wrap && !step_slot && below_sp && slow_phase && !ov_flag && !uv_flag)
        |=> (int'(duty) == ((int'($past(duty)) < MINW) ? MINW : int'($past(duty)))));

    p_full_jump_r8: assert property (@(posedge clk) disable iff (rst)
        (wrap && below_sp && !slow_phase) |=> (int'(duty) == MAXV));

endmodule

bind field_pwm_ramp fpr_checker #(
    .DUTY_W(DUTY_W), .RATIO(RATIO), .RAMP_PERIODS(RAMP_PERIODS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .below_sp    (below_sp),
    .ov_flag     (ov_flag),
    .uv_flag     (uv_flag),
    .slow_phase  (slow_phase),
    .wrap        (wrap),
    .step_slot   (step_slot),
    .field_drive (field_drive),
    .duty        (duty)
);

// File: tb/field_pwm_ramp_tb.sv
module field_pwm_ramp_tb;
    localparam int DUTY_W = 8;
    localparam int RATIO  = 4;
    localparam int RAMP_P = 40;
    localparam int FRAME  = 1 << DUTY_W;
    localparam int INC    = 26;   // R9: ceil(255 / (40/4))
    localparam int MINW   = 16;   // R5
    localparam int FULL   = 255;  // R8

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic below_sp = 1'b0;
    logic ov_flag = 1'b0;
    logic uv_flag = 1'b0;
    logic slow_phase = 1'b0;
    logic field_drive;
    logic [DUTY_W-1:0] duty;

    int n_checks = 0;
    int n_fail = 0;
    int tb_pos = 0;
    int tb_wraps = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    field_pwm_ramp #(.DUTY_W(DUTY_W), .RATIO(RATIO), .RAMP_PERIODS(RAMP_P)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .below_sp(below_sp),
        .ov_flag(ov_flag), .uv_flag(uv_flag), .slow_phase(slow_phase),
        .field_drive(field_drive), .duty(duty)
    );

    // Bench frame tracker: frame of FRAME ticks starting at reset.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            tb_pos   <= 0;
            tb_wraps <= 0;
        end else if (tick) begin
            if (tb_pos == FRAME - 1) begin
                tb_pos   <= 0;
                tb_wraps <= tb_wraps + 1;
            end else begin
                tb_pos <= tb_pos + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Return at the falling edge just after the next frame boundary.
    task automatic next_wrap();
        int w0;
        w0 = tb_wraps;
        while (tb_wraps == w0) @(negedge clk);
    endtask

    // Count high field ticks across one frame starting at a boundary.
    task automatic count_high(output int hi);
        hi = 0;
        for (int i = 0; i < FRAME; i++) begin
            if (field_drive) hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        @(negedge clk);
        check("R1", "duty in reset", int'(duty), 0);
        check("R1", "field in reset", int'(field_drive), 0);
        rst  = 1'b0;
        tick = 1'b1;
        @(negedge clk);
        check("R1", "field after reset", int'(field_drive), 0);
    endtask

    task automatic t_window_floor();
        int hi;
        below_sp = 1'b0;
        next_wrap();
        check("R5", "window floor", int'(duty), MINW);
        count_high(hi);
        check("R2", "high ticks at floor", hi, MINW);
    endtask

    task automatic t_overvolt();
        int hi;
        ov_flag = 1'b1;
        next_wrap();
        check("R6", "floor with overvoltage", int'(duty), 0);
        count_high(hi);
        check("R6", "no pulse with overvoltage", hi, 0);
        ov_flag = 1'b0;
        uv_flag = 1'b1;
        next_wrap();
        check("R6", "floor with undervoltage", int'(duty), 0);
        uv_flag = 1'b0;
        next_wrap();
        check("R5", "floor restored", int'(duty), MINW);
    endtask

    task automatic t_full_jump();
        int hi;
        below_sp = 1'b1;
        slow_phase = 1'b0;
        next_wrap();
        check("R8", "jump to full", int'(duty), FULL);
        count_high(hi);
        check("R2", "high ticks at full", hi, FULL);
        below_sp = 1'b0;
        next_wrap();
        check("R4", "immediate drop", int'(duty), MINW);
    endtask

    task automatic t_latch();
        below_sp = 1'b0;
        slow_phase = 1'b0;
        repeat (40) @(negedge clk);
        below_sp = 1'b1;
        repeat (120) @(negedge clk);
        below_sp = 1'b0;
        next_wrap();
        check("R3", "mid-frame comparator ignored", int'(duty), MINW);
    endtask

    task automatic t_tick_gate();
        logic f0;
        logic [DUTY_W-1:0] d0;
        int moved;
        int hi;
        moved = 0;
        repeat (8) @(negedge clk);
        tick = 1'b0;
        below_sp = 1'b1;   // would jump to full if a boundary happened
        f0 = field_drive;
        d0 = duty;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (field_drive !== f0 || duty !== d0) moved++;
        end
        check("R2", "outputs frozen without tick", moved, 0);
        check("R2", "field high at frozen position", int'(f0), 1);
        below_sp = 1'b0;
        tick = 1'b1;
        next_wrap();
        check("R2", "duty after stretched frame", int'(duty), MINW);
        count_high(hi);
        check("R2", "high ticks after gap", hi, MINW);
    endtask

    task automatic t_ramp();
        int exp;
        int extra;
        exp = MINW;
        extra = 0;
        slow_phase = 1'b1;
        below_sp = 1'b1;
        while (extra < 3) begin
            next_wrap();
            if (tb_wraps % RATIO == 0) exp = (exp + INC > FULL) ? FULL : exp + INC;
            check("R7", "ramp value", int'(duty), exp);
            if (exp == FULL) extra++;
        end
    endtask

    task automatic t_ramp_start();
        below_sp = 1'b0;
        next_wrap();
        check("R4", "drop from full under ramp", int'(duty), MINW);
        below_sp = 1'b1;
        while (tb_wraps % RATIO != 0) next_wrap();
        check("R9", "one step from floor", int'(duty), MINW + INC);
    endtask

    task automatic t_drop_on_step();
        while (tb_wraps % RATIO != RATIO - 1) next_wrap();
        below_sp = 1'b0;
        next_wrap();
        check("R10", "boundary was a step slot", tb_wraps % RATIO, 0);
        check("R10", "drop wins over step", int'(duty), MINW);
        below_sp = 1'b1;
        next_wrap();
        check("R7", "hold after drop", int'(duty), MINW);
    endtask

    initial begin
        while (cyc < 150000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d, expected end before limit", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_window_floor();
        t_overvolt();
        t_full_jump();
        t_latch();
        t_tick_gate();
        t_ramp();
        t_ramp_start();
        t_drop_on_step();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule